// File: doc/BRIEF.md
# SPI EEPROM Command Front End

This block is the serial slave side of a 256-byte serial EEPROM. It watches the chip-select, serial-clock, serial-data and hold pins, all already synchronised to the system clock. It gathers a one-byte command and then any address and data bytes that follow. It turns these into single-cycle requests to a storage and protection unit. That unit holds the array, the status register and the programming timer. The front end drives the serial output together with an enable that stands for its tri-state control.

Bits are sampled on rising serial-clock edges and shifted out after falling edges, most significant bit first. Clock polarity 0 and 1 both work because only edges are used. Single-byte commands, completed status reads and unknown commands park the block until the next deselect. The hold pin pauses the transfer without losing its place. Every pin is sampled on the system clock, so each serial-clock half period must last at least three system clocks. The storage unit must present read data in the cycle after a read request and keep it until the next request.

Top module: `spi_eeprom_front`

## Requirements
- R1: With the clock idling low or idling high, input bits are taken on rising edges and output bits change after falling edges, MSB first.
- R2: Command 0x06 gives one `wel_set` pulse and command 0x04 gives one `wel_clr` pulse. Any bytes that follow in the same selection are ignored.
- R3: A command byte outside {0x01, 0x02, 0x03, 0x04, 0x05, 0x06} keeps the output disabled and raises no request until chip select goes high.
- R4: Command 0x05 returns `status_i` once. On the falling edge after its eighth bit the output is disabled and later input is ignored.
- R5: Command 0x03 takes an address byte, then returns the byte at that address followed by consecutive bytes. The address wraps from 0xFF to 0x00.
- R6: Command 0x02 takes an address byte. Each complete data byte gives one `wr_req` carrying the current address and that byte, and the address then advances with wrap. A partial byte gives no request.
- R7: Command 0x01 gives one `sr_wr_req` with the data byte, on the rise of chip select, only when exactly eight data bits were clocked in.
- R8: While chip select is high the output is disabled from the next cycle on, and a selection cut short raises no further requests. After reset the output is disabled.
- R9: After reset, no command is accepted until chip select has gone from high to low.
- R10: Hold starts when `hold_n` falls while the clock is low and ends when it rises while the clock is low. While held, the output is disabled and clock and data have no effect.
- R11: A fall of `hold_n` while the clock is high does not start a hold.
- R12: Deselecting while held returns the block to idle, and the next selection starts a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, synchronised |
| sck | input | 1 | Serial clock, synchronised |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (0 = high impedance) |
| status_i | input | 8 | Status byte from the storage unit |
| rd_data | input | 8 | Read data, valid the cycle after `rd_req` |
| mem_addr | output | AW | Address for `rd_req` and `wr_req` |
| mem_wdata | output | 8 | Data for `wr_req` and `sr_wr_req` |
| rd_req | output | 1 | Array read request pulse |
| wr_req | output | 1 | Array write request pulse |
| sr_wr_req | output | 1 | Status write request pulse |
| wel_set | output | 1 | Set write-enable pulse |
| wel_clr | output | 1 | Clear write-enable pulse |

## Verification
The assertions assume clean, already synchronised pins. They expect each serial-clock level to last long enough that no two edges of it fall within two system clocks. They also expect hold changes to be seen only while the block is selected. The stimulus drives every pin on falling system-clock edges and holds each serial-clock phase for four system clocks. Changes to hold and chip select happen only while the serial clock stands still, so each edge the block sees is a single clean event.

// File: rtl/spi_eep_pkg.sv
`timescale 1ns/1ps
// Shared types and command codes for the serial EEPROM front end.
// Assumes an eight-bit command byte; the codes set the command behaviour.
package spi_eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,     // deselected or waiting for a select edge
        ST_OPC,      // gathering the command byte
        ST_RD_ADDR,  // gathering the read address
        ST_WR_ADDR,  // gathering the write address
        ST_RD_OUT,   // streaming array bytes out
        ST_WR_DATA,  // gathering bytes to write
        ST_SR_OUT,   // status byte not yet loaded
        ST_SR_TAIL,  // status byte being shifted
        ST_SR_IN,    // gathering the new status byte
        ST_SR_FULL,  // status byte complete, waiting for deselect
        ST_PARK      // ignoring everything until deselect
    } fe_state_t;

    localparam logic [7:0] CMD_WEL_SET   = 8'h06;
    localparam logic [7:0] CMD_WEL_CLR   = 8'h04;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;
    localparam logic [7:0] CMD_ARR_RD    = 8'h03;
    localparam logic [7:0] CMD_ARR_WR    = 8'h02;

endpackage

// File: rtl/spi_pin_edges.sv
`timescale 1ns/1ps
// Edge detector for a group of synchronised pins.
// Assumes the pins are already synchronous to clk. RST_VAL sets the level
// taken as "previous" after reset, which decides whether a pin held at a
// given level through reset shows an edge.
module spi_pin_edges #(
    parameter int             N       = 3,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    // Remember each pin's level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= pin;
    end

    // One rise/fall pair for each pin.
    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] = pin[g] & ~prev_q[g];
        assign fall[g] = ~pin[g] & prev_q[g];
    end

endmodule

// File: rtl/spi_hold_gate.sv
`timescale 1ns/1ps
// Pause tracker. Hold begins on a falling hold edge seen while the serial
// clock is low and ends on a rising hold edge seen while it is low.
// Deselect drops the hold at once. Assumes synchronised pins.
module spi_hold_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_fall,
    input  logic hold_rise,
    output logic hold_q
);

    // Enter or leave the pause on edge-qualified hold transitions.
    always_ff @(posedge clk) begin
        if (!rst_n)                            hold_q <= 1'b0;
        else if (cs_n)                         hold_q <= 1'b0;
        else if (!hold_q && hold_fall && !sck) hold_q <= 1'b1;
        else if (hold_q && hold_rise && !sck)  hold_q <= 1'b0;
    end

    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> $past(!sck) && $past(!cs_n)); // R10

    AST_HOLD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !hold_q); // R12

endmodule

// File: rtl/spi_rx_shift.sv
`timescale 1ns/1ps
// Input shifter. Takes one bit, MSB first, on each enabled cycle and flags
// the cycle that completes a word. byte_nxt is the word including the bit
// now being taken. Clearing restarts the word.
module spi_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         si,
    output logic         byte_done,
    output logic [W-1:0] byte_nxt
);

    localparam int             CW   = $clog2(W);
    localparam logic [CW-1:0]  LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  sr_q;

    assign byte_nxt  = {sr_q[W-2:0], si};
    assign byte_done = shift_en && (cnt_q == LAST);

    // Shift in one bit and count it, wrapping at the word boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (shift_en) begin
            sr_q  <= byte_nxt;
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/spi_tx_shift.sv
`timescale 1ns/1ps
// Output shifter. On an enabled cycle at a word boundary it loads load_val
// and presents its MSB; on other enabled cycles it presents the next bit.
// at_boundary is high when the next enabled cycle loads a new word.
module spi_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic [W-1:0] load_val,
    output logic         so_bit,
    output logic         at_boundary
);

    localparam int             CW   = $clog2(W);
    localparam logic [CW-1:0]  LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  sr_q;

    assign at_boundary = (cnt_q == '0);

    // Load or advance the outgoing word one bit per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sr_q   <= '0;
            so_bit <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
        end else if (shift_en) begin
            if (at_boundary) begin
                so_bit <= load_val[W-1];
                sr_q   <= {load_val[W-2:0], 1'b0};
            end else begin
                so_bit <= sr_q[W-1];
                sr_q   <= {sr_q[W-2:0], 1'b0};
            end
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/spi_eeprom_front.sv
`timescale 1ns/1ps
// Serial EEPROM command front end. Decodes the command byte, collects the
// address and data bytes, streams read and status bytes out, and issues
// one-cycle requests to the storage unit. Assumes synchronised pins, each
// serial clock phase lasting at least three clk cycles, and rd_data valid
// from the cycle after rd_req until the next rd_req.
module spi_eeprom_front
    import spi_eep_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          si,
    input  logic          hold_n,
    output logic          so,
    output logic          so_oe,
    input  logic [7:0]    status_i,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          rd_req,
    output logic          wr_req,
    output logic          sr_wr_req,
    output logic          wel_set,
    output logic          wel_clr
);

    localparam int BW = 8;

    // Pin edges; bit 0 chip select, bit 1 clock, bit 2 hold.
    logic [2:0] pin_rise, pin_fall;
    logic       cs_fall, cs_rise, sck_rise, sck_fall, hold_fall, hold_rise;
    logic       hold_q, active;
    logic       byte_done, tx_boundary, tx_shift, so_bit;
    logic [BW-1:0] byte_nxt, tx_load;
    logic [AW-1:0] ptr_q;
    logic          oe_q;
    fe_state_t     state;

    spi_pin_edges #(.N(3), .RST_VAL(3'b100)) i_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({hold_n, sck, cs_n}),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign cs_fall   = pin_fall[0];
    assign cs_rise   = pin_rise[0];
    assign sck_rise  = pin_rise[1];
    assign sck_fall  = pin_fall[1];
    assign hold_rise = pin_rise[2];
    assign hold_fall = pin_fall[2];

    spi_hold_gate i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .hold_fall (hold_fall),
        .hold_rise (hold_rise),
        .hold_q    (hold_q)
    );

    assign active = !cs_n && !hold_q;

    spi_rx_shift #(.W(BW)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cs_n),
        .shift_en  (active && sck_rise),
        .si        (si),
        .byte_done (byte_done),
        .byte_nxt  (byte_nxt)
    );

    assign tx_shift = active && sck_fall &&
                      (state == ST_RD_OUT || state == ST_SR_OUT || state == ST_SR_TAIL);
    assign tx_load  = (state == ST_RD_OUT) ? rd_data : status_i;

    spi_tx_shift #(.W(BW)) i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (cs_n),
        .shift_en    (tx_shift),
        .load_val    (tx_load),
        .so_bit      (so_bit),
        .at_boundary (tx_boundary)
    );

    assign so    = so_bit;
    assign so_oe = oe_q && !hold_q;

    // Command sequencer: decode, address and data phases, request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ptr_q     <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            oe_q      <= 1'b0;
            rd_req    <= 1'b0;
            wr_req    <= 1'b0;
            sr_wr_req <= 1'b0;
            wel_set   <= 1'b0;
            wel_clr   <= 1'b0;
        end else begin
            rd_req    <= 1'b0;
            wr_req    <= 1'b0;
            sr_wr_req <= 1'b0;
            wel_set   <= 1'b0;
            wel_clr   <= 1'b0;
            if (cs_n) begin
                if (cs_rise && state == ST_SR_FULL && !hold_q) sr_wr_req <= 1'b1;
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else if (!hold_q) begin
                unique case (state)
                    ST_IDLE: begin
                        if (cs_fall) state <= ST_OPC;
                    end
                    ST_OPC: begin
                        if (byte_done) begin
                            unique case (byte_nxt)
                                CMD_WEL_SET: begin wel_set <= 1'b1; state <= ST_PARK; end
                                CMD_WEL_CLR: begin wel_clr <= 1'b1; state <= ST_PARK; end
                                CMD_STAT_RD: state <= ST_SR_OUT;
                                CMD_STAT_WR: state <= ST_SR_IN;
                                CMD_ARR_RD:  state <= ST_RD_ADDR;
                                CMD_ARR_WR:  state <= ST_WR_ADDR;
                                default:     state <= ST_PARK;
                            endcase
                        end
                    end
                    ST_RD_ADDR: begin
                        if (byte_done) begin
                            ptr_q    <= byte_nxt[AW-1:0];
                            mem_addr <= byte_nxt[AW-1:0];
                            rd_req   <= 1'b1;
                            state    <= ST_RD_OUT;
                        end
                    end
                    ST_RD_OUT: begin
                        if (sck_fall && tx_boundary) begin
                            oe_q     <= 1'b1;
                            ptr_q    <= ptr_q + AW'(1);
                            mem_addr <= ptr_q + AW'(1);
                            rd_req   <= 1'b1;
                        end
                    end
                    ST_WR_ADDR: begin
                        if (byte_done) begin
                            ptr_q <= byte_nxt[AW-1:0];
                            state <= ST_WR_DATA;
                        end
                    end
                    ST_WR_DATA: begin
                        if (byte_done) begin
                            mem_addr  <= ptr_q;
                            mem_wdata <= byte_nxt;
                            wr_req    <= 1'b1;
                            ptr_q     <= ptr_q + AW'(1);
                        end
                    end
                    ST_SR_OUT: begin
                        if (sck_fall) begin
                            oe_q  <= 1'b1;
                            state <= ST_SR_TAIL;
                        end
                    end
                    ST_SR_TAIL: begin
                        if (sck_fall && tx_boundary) begin
                            oe_q  <= 1'b0;
                            state <= ST_PARK;
                        end
                    end
                    ST_SR_IN: begin
                        if (byte_done) begin
                            mem_wdata <= byte_nxt;
                            state     <= ST_SR_FULL;
                        end
                    end
                    ST_SR_FULL: begin
                        if (sck_rise) state <= ST_PARK;
                    end
                    ST_PARK: begin
                        oe_q <= 1'b0;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe); // R8

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_req, wr_req, sr_wr_req, wel_set, wel_clr}) <= 1); // R2

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q && !cs_n |=> $stable(state)); // R10

    AST_CMD_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPC) && ($past(state) == ST_IDLE) |-> $past(cs_fall)); // R9

    AST_PARK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARK) && ($past(state) == ST_PARK) |-> !so_oe && !rd_req && !wr_req); // R3

endmodule

// File: tb/test_spi_eeprom_front.sv
`timescale 1ns/1ps
module test_spi_eeprom_front;

    localparam int         HP        = 4;
    localparam logic [7:0] STAT_VAL  = 8'hF6;
    localparam logic [7:0] RD_SALT   = 8'h5A;
    localparam int         NVEC      = 12;

    // Vector: [28] clock idle level, [27:20] command, [19:12] address,
    // [11:8] byte count, [7:0] data or trailing byte.
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b0, 8'h03, 8'h10, 4'd3, 8'h00},
        {1'b1, 8'h03, 8'hFE, 4'd3, 8'h00},
        {1'b0, 8'h02, 8'h40, 4'd2, 8'h3C},
        {1'b1, 8'h02, 8'hFF, 4'd2, 8'hC3},
        {1'b0, 8'h05, 8'h00, 4'd0, 8'h00},
        {1'b1, 8'h05, 8'h00, 4'd0, 8'h00},
        {1'b0, 8'h06, 8'h00, 4'd0, 8'h04},
        {1'b1, 8'h04, 8'h00, 4'd0, 8'h06},
        {1'b0, 8'h01, 8'h00, 4'd0, 8'h0C},
        {1'b1, 8'h01, 8'h00, 4'd0, 8'h08},
        {1'b0, 8'hFF, 8'h00, 4'd0, 8'h00},
        {1'b1, 8'h03, 8'h7F, 4'd2, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       hold_n = 1'b1;
    logic [7:0] rd_data = 8'h00;
    logic       so, so_oe, rd_req, wr_req, sr_wr_req, wel_set, wel_clr;
    logic [7:0] mem_addr, mem_wdata;

    int checks = 0;
    int errors = 0;
    logic cur_cpol = 1'b0;

    int n_rd = 0, n_wr = 0, n_sr = 0, n_set = 0, n_clr = 0, n_oe = 0;
    logic [7:0] wr_addr_log [16];
    logic [7:0] wr_data_log [16];
    logic [7:0] sr_last = 8'h00;

    always #2 clk = ~clk;

    spi_eeprom_front #(.AW(8)) i_spi_eeprom_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .si        (si),
        .hold_n    (hold_n),
        .so        (so),
        .so_oe     (so_oe),
        .status_i  (STAT_VAL),
        .rd_data   (rd_data),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .sr_wr_req (sr_wr_req),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr)
    );

    // Storage model: read data appears the cycle after a request.
    always @(posedge clk) if (rd_req) rd_data <= mem_addr ^ RD_SALT;

    // Request monitor.
    always @(posedge clk) begin
        if (rst_n) begin
            if (rd_req) n_rd <= n_rd + 1;
            if (wr_req) begin
                wr_addr_log[n_wr % 16] <= mem_addr;
                wr_data_log[n_wr % 16] <= mem_wdata;
                n_wr <= n_wr + 1;
            end
            if (sr_wr_req) begin
                sr_last <= mem_wdata;
                n_sr <= n_sr + 1;
            end
            if (wel_set) n_set <= n_set + 1;
            if (wel_clr) n_clr <= n_clr + 1;
            if (so_oe)   n_oe <= n_oe + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_x(input logic b, output logic r);
        if (sck) sck = 1'b0;
        si = b;
        tick(HP);
        r = so;
        sck = 1'b1;
        tick(HP);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_x(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic start_frame(input logic cpol);
        cur_cpol = cpol;
        sck = cpol;
        tick(4);
        cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic end_frame();
        if (!cur_cpol && sck) begin
            sck = 1'b0;
            tick(HP);
        end
        cs_n = 1'b1;
        tick(HP);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog R8 actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors + 1);
        $finish;
    end

    initial begin
        logic [7:0] rx, exp_b, a;
        logic r;
        int b_rd, b_wr, b_sr, b_set, b_clr, b_oe;

        // Reset state, select held low through reset.
        tick(3);
        chk("R8 reset oe", so_oe, 0);
        chk("R8 reset rd_req", rd_req, 0);
        tick(2);
        rst_n = 1'b1;
        tick(2);

        // R9: no select edge since reset, so a read command is ignored.
        b_rd = n_rd; b_oe = n_oe;
        cur_cpol = 1'b0;
        xfer(8'h03, rx);
        xfer(8'h20, rx);
        xfer(8'h00, rx);
        end_frame();
        chk("R9 requests", n_rd - b_rd, 0);
        chk("R9 output", n_oe - b_oe, 0);

        // Vector table.
        for (int v = 0; v < NVEC; v++) begin
            logic       cp;
            logic [7:0] op, ad, dt;
            int         nb;
            string      tag;
            cp = VEC[v][28]; op = VEC[v][27:20]; ad = VEC[v][19:12];
            nb = int'(VEC[v][11:8]); dt = VEC[v][7:0];
            tag = cp ? "R1" : "R5";
            b_rd = n_rd; b_wr = n_wr; b_sr = n_sr; b_set = n_set; b_clr = n_clr; b_oe = n_oe;
            start_frame(cp);
            xfer(op, rx);
            case (op)
                8'h03: begin
                    xfer(ad, rx);
                    for (int i = 0; i < nb; i++) begin
                        xfer(8'h00, rx);
                        a = ad + 8'(i);
                        chk(tag, rx, a ^ RD_SALT);
                    end
                    end_frame();
                end
                8'h02: begin
                    xfer(ad, rx);
                    for (int i = 0; i < nb; i++) xfer(dt + 8'(i * 17), rx);
                    end_frame();
                    tick(2);
                    chk("R6 count", n_wr - b_wr, nb);
                    for (int i = 0; i < nb; i++) begin
                        a = ad + 8'(i);
                        chk("R6 addr", wr_addr_log[(b_wr + i) % 16], a);
                        chk("R6 data", wr_data_log[(b_wr + i) % 16], dt + 8'(i * 17));
                    end
                end
                8'h05: begin
                    xfer(8'h00, rx);
                    chk("R4 status", rx, STAT_VAL);
                    if (!cp) begin
                        sck = 1'b0;
                        tick(HP);
                        chk("R4 hiz after byte", so_oe, 0);
                        xfer(8'h06, rx);
                        chk("R4 ignored input", so_oe, 0);
                    end
                    end_frame();
                    tick(2);
                    chk("R4 no set", n_set - b_set, 0);
                end
                8'h06, 8'h04: begin
                    xfer(dt, rx);
                    end_frame();
                    tick(2);
                    chk("R2 set", n_set - b_set, (op == 8'h06) ? 1 : 0);
                    chk("R2 clr", n_clr - b_clr, (op == 8'h04) ? 1 : 0);
                end
                8'h01: begin
                    xfer(dt, rx);
                    end_frame();
                    tick(2);
                    chk("R7 count", n_sr - b_sr, 1);
                    chk("R7 data", sr_last, dt);
                end
                default: begin
                    xfer(8'h03, rx);
                    xfer(8'h20, rx);
                    xfer(8'h00, rx);
                    end_frame();
                    tick(2);
                    chk("R3 requests", n_rd - b_rd, 0);
                    chk("R3 output", n_oe - b_oe, 0);
                end
            endcase
            chk("R8 deselected oe", so_oe, 0);
        end

        // R7: nine status data bits abort the status write.
        b_sr = n_sr;
        start_frame(1'b0);
        xfer(8'h01, rx);
        xfer(8'h0C, rx);
        bit_x(1'b1, r);
        end_frame();
        tick(2);
        chk("R7 nine bits", n_sr - b_sr, 0);

        // R6: a partial trailing byte makes no request.
        b_wr = n_wr;
        start_frame(1'b0);
        xfer(8'h02, rx);
        xfer(8'h30, rx);
        xfer(8'hA5, rx);
        for (int i = 0; i < 4; i++) bit_x(1'b1, r);
        end_frame();
        tick(2);
        chk("R6 partial count", n_wr - b_wr, 1);
        chk("R6 partial data", wr_data_log[b_wr % 16], 8'hA5);

        // R10: hold in the middle of a read byte.
        start_frame(1'b0);
        xfer(8'h03, rx);
        xfer(8'h80, rx);
        xfer(8'h00, rx);
        chk("R10 first byte", rx, 8'h80 ^ RD_SALT);
        for (int i = 7; i >= 4; i--) begin
            bit_x(1'b0, r);
            rx[i] = r;
        end
        sck = 1'b0;
        tick(HP);
        hold_n = 1'b0;
        tick(2);
        chk("R10 held oe", so_oe, 0);
        b_rd = n_rd;
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; si = ~si; tick(HP);
            sck = 1'b0; tick(HP);
        end
        chk("R10 clocks ignored", n_rd - b_rd, 0);
        hold_n = 1'b1;
        tick(2);
        chk("R10 resumed oe", so_oe, 1);
        for (int i = 3; i >= 0; i--) begin
            bit_x(1'b0, r);
            rx[i] = r;
        end
        chk("R10 byte across hold", rx, 8'h81 ^ RD_SALT);
        end_frame();

        // R11: hold falls while the clock is high, so no pause starts.
        start_frame(1'b0);
        xfer(8'h03, rx);
        xfer(8'h90, rx);
        bit_x(1'b0, r);
        rx[7] = r;
        hold_n = 1'b0;
        tick(1);
        for (int i = 6; i >= 0; i--) begin
            bit_x(1'b0, r);
            rx[i] = r;
        end
        chk("R11 oe", so_oe, 1);
        hold_n = 1'b1;
        tick(1);
        chk("R11 byte", rx, 8'h90 ^ RD_SALT);
        end_frame();

        // R12: deselect while held, then a fresh status read.
        start_frame(1'b0);
        xfer(8'h03, rx);
        xfer(8'h50, rx);
        for (int i = 0; i < 3; i++) bit_x(1'b1, r);
        sck = 1'b0;
        tick(HP);
        hold_n = 1'b0;
        tick(2);
        cs_n = 1'b1;
        tick(HP);
        hold_n = 1'b1;
        tick(2);
        chk("R12 deselected oe", so_oe, 0);
        start_frame(1'b0);
        xfer(8'h05, rx);
        xfer(8'h00, rx);
        chk("R12 fresh command", rx, STAT_VAL);
        end_frame();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule